// File: doc/BRIEF.md
# Memory-Mapped Hardware Lock Bank

This block holds a bank of single-bit mutual-exclusion flags that several processors share through one simple register port. A processor tries for a flag by reading that flag's register. If the value it gets back is 0, the flag was free, and the same read has already marked it as held, so the reader now owns it. If the value is 1, another processor holds the flag and nothing changes. The owner gives the flag up by writing 0 to the same register.

Because the test and the take happen in one clock edge inside the block, two processors cannot both see the flag as free. A read-only descriptor word at offset 0 reports the size of the bank as a small code, so software can find the number of flags at run time. The number of flags is a build parameter, and only 32, 64, 128 or 256 is accepted.

The port is a plain strobe interface. Read data is registered and appears in the cycle after the read strobe.

Top module: `hwlock_bank`

## Requirements
- R1: After reset every flag is free and `bus_rdata` is 0.
- R2: A read of a free flag's register (byte offset 0x100 + 4*i, for i below the flag count) returns 0 on the next cycle, and the flag is held from then on.
- R3: A read of a held flag's register returns 1 on the next cycle, and the flag stays held.
- R4: A write of the value 0 to a flag's register frees that flag.
- R5: A write of any nonzero value to a flag's register leaves the flag unchanged.
- R6: Two reads of the same free flag on back-to-back cycles return exactly one 0, and the second read returns 1.
- R7: A read of offset 0x000 returns the size code in bits 31:28 (1 = 32 flags, 2 = 64, 3 = 128, 4 = 256) with bits 27:0 at 0. Writes to this offset change nothing.
- R8: A read or write at an unmapped offset, at a misaligned offset, or at a flag index at or above the flag count returns 0 and changes no flag.
- R9: When the read and write strobes are both high in one cycle, only the read takes effect.
- R10: In the cycle after a cycle with no read strobe, `bus_rdata` is 0.
- R11: A flag register read drives only bit 0 of `bus_rdata`. Bits 31:1 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_rd | input | 1 | Read strobe (test-and-take on a flag register) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |

## Verification
Every result is due exactly one clock edge after its strobe. The read value and the new flag state are both registered at the edge that samples `bus_rd`, and a release takes effect at the edge that samples `bus_wr`. The bench drives each access on a falling edge and updates its own model at once. It compares `bus_rdata` at the next falling edge, so a back-to-back read already sees the state left by the read before it. Random traffic from several modelled processors also checks that a flag never has two owners at the same time.

// File: rtl/hwlock_pkg.sv
package hwlock_pkg;

    localparam int unsigned DATA_W    = 32;
    localparam int unsigned LOCK_BASE = 'h100;
    localparam int unsigned CODE_LSB  = 28;
    localparam int unsigned CODE_W    = 4;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_DESC = 2'd1,
        RGN_FLAG = 2'd2
    } region_e;

    // Size code reported in the descriptor; 0 marks an unsupported count.
    function automatic logic [CODE_W-1:0] size_code(input int n);
        case (n)
            32:      return 4'd1;
            64:      return 4'd2;
            128:     return 4'd3;
            256:     return 4'd4;
            default: return 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/hwlock_decode.sv
module hwlock_decode
    import hwlock_pkg::*;
#(
    parameter int NUM_LOCKS = 32,
    parameter int ADDR_W    = 12,
    localparam int IDX_W    = $clog2(NUM_LOCKS)
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [IDX_W-1:0]  idx
);
    logic [ADDR_W-1:0] off;
    logic [ADDR_W-1:0] word;
    logic              above_base;
    logic              in_range;

    always_comb begin
        off        = addr - ADDR_W'(LOCK_BASE);
        word       = off >> 2;
        above_base = addr >= ADDR_W'(LOCK_BASE);
        in_range   = word < ADDR_W'(NUM_LOCKS);
        idx        = word[IDX_W-1:0];
        if (addr == '0)
            region = RGN_DESC;
        else if (above_base && in_range && off[1:0] == 2'b00)
            region = RGN_FLAG;
        else
            region = RGN_NONE;
    end
endmodule

// File: rtl/hwlock_store.sv
module hwlock_store #(
    parameter int NUM_LOCKS = 32,
    localparam int IDX_W    = $clog2(NUM_LOCKS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 take_en,
    input  logic                 free_en,
    input  logic [IDX_W-1:0]     idx,
    output logic                 cur_held,
    output logic [NUM_LOCKS-1:0] held_q
);
    for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_flag
        logic sel;
        assign sel = (idx == IDX_W'(g));
        always_ff @(posedge clk) begin
            if (rst)
                held_q[g] <= 1'b0;
            else if (take_en && sel)
                held_q[g] <= 1'b1;
            else if (free_en && sel)
                held_q[g] <= 1'b0;
        end
    end

    assign cur_held = held_q[idx];
endmodule

// File: rtl/hwlock_bank.sv
module hwlock_bank
    import hwlock_pkg::*;
#(
    parameter int NUM_LOCKS = 32,
    parameter int ADDR_W    = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int IDX_W = $clog2(NUM_LOCKS);
    localparam logic [CODE_W-1:0] CODE = size_code(NUM_LOCKS);

    if (CODE == '0) begin : g_bad_count
        $error("hwlock_bank: NUM_LOCKS must be 32, 64, 128 or 256");
    end
    if (ADDR_W < 11) begin : g_bad_addr
        $error("hwlock_bank: ADDR_W too small for the flag window");
    end

    region_e              region;
    logic [IDX_W-1:0]     idx;
    logic                 take_en;
    logic                 free_en;
    logic                 cur_held;
    logic [NUM_LOCKS-1:0] lock_q;
    logic [DATA_W-1:0]    rdata_d;
    logic [DATA_W-1:0]    rdata_q;

    hwlock_decode #(.NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W)) u_dec (
        .addr   (bus_addr),
        .region (region),
        .idx    (idx)
    );

    // Read has priority; a write only frees on an exact zero value.
    assign take_en = bus_rd && (region == RGN_FLAG);
    assign free_en = bus_wr && !bus_rd && (region == RGN_FLAG)
                     && (bus_wdata == '0);

    hwlock_store #(.NUM_LOCKS(NUM_LOCKS)) u_store (
        .clk      (clk),
        .rst      (rst),
        .take_en  (take_en),
        .free_en  (free_en),
        .idx      (idx),
        .cur_held (cur_held),
        .held_q   (lock_q)
    );

    always_comb begin
        rdata_d = '0;
        if (bus_rd) begin
            unique case (region)
                RGN_FLAG: rdata_d = {{(DATA_W-1){1'b0}}, cur_held};
                RGN_DESC: rdata_d = {CODE, {CODE_LSB{1'b0}}};
                default:  rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else
            rdata_q <= rdata_d;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/hwlock_bank_chk.sv
module hwlock_bank_chk
    import hwlock_pkg::*;
#(
    parameter int NUM_LOCKS = 32,
    parameter int ADDR_W    = 12,
    localparam int IDX_W    = $clog2(NUM_LOCKS)
) (
    input logic                 clk,
    input logic                 rst,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_rd,
    input logic                 bus_wr,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic [NUM_LOCKS-1:0] lock_q
);
    int unsigned a;
    int unsigned w;
    logic        flag_hit;
    logic        desc_hit;
    logic [IDX_W-1:0] cidx;
    logic [IDX_W-1:0] pidx;

    always_comb begin
        a        = int'(bus_addr);
        w        = (a - LOCK_BASE) >> 2;
        flag_hit = (a >= LOCK_BASE) && (a[1:0] == 2'b00) && (w < NUM_LOCKS);
        desc_hit = (a == 0);
        cidx     = w[IDX_W-1:0];
    end

    always_ff @(posedge clk) pidx <= cidx;

    AST_TAKE_FREE: assert property (@(posedge clk) disable iff (rst)
        bus_rd && flag_hit && !lock_q[cidx] |=> lock_q[pidx] && bus_rdata == '0); // R2
    AST_HELD_STAYS: assert property (@(posedge clk) disable iff (rst)
        bus_rd && flag_hit && lock_q[cidx] |=> lock_q[pidx] && bus_rdata == 32'd1); // R3
    AST_NONZERO_WRITE: assert property (@(posedge clk) disable iff (rst)
        bus_wr && !bus_rd && bus_wdata != '0 |=> $stable(lock_q)); // R5
    AST_DESC_READ: assert property (@(posedge clk) disable iff (rst)
        bus_rd && desc_hit |=> bus_rdata[CODE_LSB-1:0] == '0
            && bus_rdata[DATA_W-1:CODE_LSB] == size_code(NUM_LOCKS)); // R7
    AST_UNMAPPED: assert property (@(posedge clk) disable iff (rst)
        (bus_rd || bus_wr) && !flag_hit |=> $stable(lock_q)); // R8
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_rd && !flag_hit && !desc_hit |=> bus_rdata == '0); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> bus_rdata == '0); // R10
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_rd && flag_hit |=> bus_rdata[DATA_W-1:1] == '0); // R11
endmodule

bind hwlock_bank hwlock_bank_chk #(.NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .lock_q    (lock_q)
);

// File: tb/hwlock_bank_test.sv
module hwlock_bank_test;
    localparam int N  = 64;
    localparam int AW = 12;
    localparam int MASTERS = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    bit model[N];
    int owner[N];

    always #2.5 clk = ~clk;

    hwlock_bank #(.NUM_LOCKS(N), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic int flag_index(input int a);
        if (a >= 'h100 && a % 4 == 0 && (a - 'h100) / 4 < N)
            return (a - 'h100) / 4;
        return -1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at a falling edge, compare at the next one.
    task automatic access(input bit rd, input bit wr, input int a, input int wd,
                          input string req, output int got);
        int i;
        int exp;
        bus_rd = rd; bus_wr = wr; bus_addr = AW'(a); bus_wdata = wd;
        i = flag_index(a);
        exp = 0;
        if (rd) begin
            if (a == 0) exp = 2 << 28;
            else if (i >= 0) begin
                exp = int'(model[i]);
                model[i] = 1'b1;
            end
        end else if (wr && i >= 0 && wd == 0) begin
            model[i] = 1'b0;
        end
        @(negedge clk);
        got = int'(bus_rdata);
        check(bus_rdata == 32'(exp), req, got, exp);
        bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic idle(input string req);
        int got;
        access(1'b0, 1'b0, 'h104, 0, req, got);
    endtask

    initial begin
        int got;
        for (int k = 0; k < N; k++) begin model[k] = 1'b0; owner[k] = -1; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(bus_rdata == 0, "R1 rdata after reset", int'(bus_rdata), 0);
        // R1: every flag free after reset
        for (int k = 0; k < N; k++) access(1'b1, 1'b0, 'h100 + 4*k, 0, "R1 R2 first read", got);
        access(1'b1, 1'b0, 'h100, 0, "R3 held read", got);
        access(1'b0, 1'b1, 'h100, 0, "R4 release", got);
        access(1'b1, 1'b0, 'h100, 0, "R4 reads free", got);
        access(1'b0, 1'b1, 'h104, 1, "R5 nonzero write", got);
        access(1'b0, 1'b1, 'h104, 32'h8000_0000, "R5 high bit write", got);
        access(1'b1, 1'b0, 'h104, 0, "R5 still held", got);
        access(1'b0, 1'b1, 'h108, 0, "R4 release 2", got);
        access(1'b1, 1'b0, 'h108, 0, "R6 first of pair", got);
        access(1'b1, 1'b0, 'h108, 0, "R6 second of pair", got);
        check(got == 1, "R6 second read sees held", got, 1);
        access(1'b1, 1'b0, 'h000, 0, "R7 descriptor", got);
        access(1'b0, 1'b1, 'h000, 0, "R7 descriptor write", got);
        access(1'b1, 1'b0, 'h000, 0, "R7 descriptor after write", got);
        access(1'b0, 1'b1, 'h10C, 0, "R4 release 3", got);
        access(1'b1, 1'b0, 'h10E, 0, "R8 misaligned", got);
        access(1'b1, 1'b0, 'h100 + 4*N, 0, "R8 beyond count", got);
        access(1'b1, 1'b0, 'h080, 0, "R8 unmapped", got);
        access(1'b0, 1'b1, 'h10D, 0, "R8 misaligned write", got);
        access(1'b1, 1'b0, 'h10C, 0, "R8 flag untouched", got);
        access(1'b1, 1'b1, 'h10C, 0, "R9 read wins", got);
        access(1'b1, 1'b0, 'h10C, 0, "R9 still held", got);
        access(1'b0, 1'b1, 'h110, 0, "R4 release 4", got);
        access(1'b1, 1'b0, 'h110, 0, "R11 free read", got);
        idle("R10 idle zero");
        // random traffic from several processors
        for (int k = 0; k < N; k++) access(1'b0, 1'b1, 'h100 + 4*k, 0, "R4 clear", got);
        for (int c = 0; c < 4000; c++) begin
            int m = $urandom_range(MASTERS - 1);
            int i = $urandom_range(N + 3);
            int act = $urandom_range(9);
            if (act < 4 && i < N && owner[i] == m) begin
                access(1'b0, 1'b1, 'h100 + 4*i, 0, "R4 random release", got);
                owner[i] = -1;
            end else if (act == 4) begin
                access(1'b0, 1'b1, 'h100 + 4*i, $urandom_range(255) + 1, "R5 random write", got);
            end else if (act == 5) begin
                idle("R10 random idle");
            end else begin
                access(1'b1, 1'b0, 'h100 + 4*i, 0, "R2 R3 random read", got);
                if (i < N && got == 0) begin
                    check(owner[i] == -1, "R6 single owner", owner[i], -1);
                    owner[i] = m;
                end
            end
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule